// File: doc/BRIEF.md
# E1 Receive Alarm Latch and Error Counters

This block collects the status of an E1 receive path so that a host can poll it. The receive framer sends it single-cycle strobes: seven alarm events, one strobe for each frame alignment word that arrived with errors, and one strobe for each E-bit error. Each alarm event sets a sticky bit that holds until the host reads the alarm byte. Error strobes advance saturating counters.

The host reads through a byte-wide port with a 2-bit address and a read strobe. Read data is registered and appears one cycle after the strobe. Reading a byte that clears state returns the value from before the clear. An event that arrives in the same cycle as that read is kept, not lost.

The E-bit counter is wider than one byte. A read of its upper byte captures the lower byte at the same moment, so that the next lower-byte read returns a matching pair.

Top module: `e1_alarm_counters`

## Requirements
- R1: Address 0 returns the alarm byte: bit 7 remote alarm, bit 6 all-ones alarm, bit 5 all-ones alarm in time slot 16, bit 4 loss of signal, bit 3 auxiliary pattern, bit 2 multiframe alarm, bit 1 receive slip, and bit 0 always zero.
- R2: An alarm bit goes to one when its event strobe is high, and stays at one in every later cycle until address 0 is read.
- R3: A read of address 0 returns the latched bits and clears all of them in the same clock edge.
- R4: An alarm event in the same cycle as a read of address 0 is absent from that read's data, but its bit is set after the clear.
- R5: Address 1 returns an 8-bit errored-alignment count. It adds one per strobe. A read of address 1 returns the count and leaves it at zero, or at one if a strobe arrives in that same cycle.
- R6: Both counters saturate at all ones and never wrap: 255 for the alignment counter and 1023 for the E-bit counter.
- R7: The E-bit error count is 10 bits. Address 2 returns bits 9:8 of the count in data bits 1:0, with data bits 7:2 zero, and this read does not change the count. Address 3 returns the low 8 bits. A read of address 3 clears the count to zero, or to one if an E-bit strobe arrives in that same cycle.
- R8: A read of address 2 captures the low 8 bits of the count at that edge. The next read of address 3 returns the captured byte. A read of address 3 with no address 2 read since the last address 3 read returns the live low byte.
- R9: Read data is valid in the cycle after the read strobe and is zero in the cycle after a cycle with no read strobe.
- R10: A synchronous active-high reset clears all alarm bits, both counters, the captured byte and the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_rai | input | 1 | Remote alarm event strobe |
| evt_ais | input | 1 | All-ones alarm event strobe |
| evt_ais16 | input | 1 | All-ones alarm in time slot 16 strobe |
| evt_los | input | 1 | Loss of signal strobe |
| evt_aux | input | 1 | Auxiliary pattern strobe |
| evt_mfa | input | 1 | Multiframe alarm strobe |
| evt_slip | input | 1 | Receive elastic-store slip strobe |
| evt_fas_err | input | 1 | Errored alignment word strobe |
| evt_ebit_err | input | 1 | E-bit error strobe |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 2 | Host read address |
| rd_data | output | 8 | Registered read data |

## Verification
The bench drives events in the same cycles as clearing reads, for both alarms and counters. A design that applied the clear after the event would drop the event silently. It also pushes each counter well past its maximum before reading it, which exposes a wrap to a small value. It reads the upper E-bit byte, then adds more E-bit errors before reading the lower byte. A design without the capture register would return a lower byte that does not match the upper byte. A final reset in the middle of activity checks that no latched bit, count or captured byte survives the reset.

// File: rtl/e1_stat_pkg.sv
package e1_stat_pkg;

    localparam int ADDR_W = 2;
    localparam int BYTE_W = 8;
    localparam int ALARM_N = 7;

    typedef enum logic [ADDR_W-1:0] {
        RA_ALARM   = 2'd0,
        RA_FAS     = 2'd1,
        RA_EBIT_HI = 2'd2,
        RA_EBIT_LO = 2'd3
    } reg_addr_e;

    // Field order matches the alarm byte, most significant first.
    typedef struct packed {
        logic rai;
        logic ais;
        logic ais16;
        logic los;
        logic aux;
        logic mfa;
        logic slip;
    } alarm_t;

    function automatic logic [BYTE_W-1:0] alarm_byte(input alarm_t a);
        return {a, 1'b0};
    endfunction

    function automatic alarm_t alarm_next(input alarm_t cur, input alarm_t evt,
                                          input logic clr);
        return clr ? evt : (cur | evt);
    endfunction

endpackage

// File: rtl/e1_alarm_latch.sv
module e1_alarm_latch
    import e1_stat_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  alarm_t evt,
    input  logic   clr,
    output alarm_t q
);

    alarm_t q_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= '0;
        end else begin
            q_r <= alarm_next(q_r, evt, clr);
        end
    end

    assign q = q_r;

endmodule

// File: rtl/e1_sat_counter.sv
module e1_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;

    always_comb begin
        if (clr) begin
            cnt_d = W'(inc);
        end else if (inc && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/e1_stat_readout.sv
module e1_stat_readout
    import e1_stat_pkg::*;
#(
    parameter int FAS_W = 8,
    parameter int EB_W  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  alarm_t            alm,
    input  logic [FAS_W-1:0]  fas_cnt,
    input  logic [EB_W-1:0]   eb_cnt,
    output logic              clr_alm,
    output logic              clr_fas,
    output logic              clr_eb,
    output logic [BYTE_W-1:0] rd_data
);

    reg_addr_e         addr;
    logic              snap_vld_q;
    logic [BYTE_W-1:0] snap_q;
    logic [BYTE_W-1:0] rd_d;
    logic [BYTE_W-1:0] rd_q;
    logic              take_snap;

    assign addr      = reg_addr_e'(rd_addr);
    assign clr_alm   = rd_en && (addr == RA_ALARM);
    assign clr_fas   = rd_en && (addr == RA_FAS);
    assign clr_eb    = rd_en && (addr == RA_EBIT_LO);
    assign take_snap = rd_en && (addr == RA_EBIT_HI);

    always_comb begin
        rd_d = '0;
        if (rd_en) begin
            unique case (addr)
                RA_ALARM:   rd_d = alarm_byte(alm);
                RA_FAS:     rd_d = BYTE_W'(fas_cnt);
                RA_EBIT_HI: rd_d = BYTE_W'(eb_cnt >> BYTE_W);
                RA_EBIT_LO: rd_d = snap_vld_q ? snap_q : eb_cnt[BYTE_W-1:0];
                default:    rd_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q       <= '0;
            snap_q     <= '0;
            snap_vld_q <= 1'b0;
        end else begin
            rd_q <= rd_d;
            if (take_snap) begin
                snap_q     <= eb_cnt[BYTE_W-1:0];
                snap_vld_q <= 1'b1;
            end else if (clr_eb) begin
                snap_vld_q <= 1'b0;
            end
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/e1_alarm_counters.sv
module e1_alarm_counters
    import e1_stat_pkg::*;
#(
    parameter int FAS_W = 8,
    parameter int EB_W  = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        evt_rai,
    input  logic        evt_ais,
    input  logic        evt_ais16,
    input  logic        evt_los,
    input  logic        evt_aux,
    input  logic        evt_mfa,
    input  logic        evt_slip,
    input  logic        evt_fas_err,
    input  logic        evt_ebit_err,
    input  logic        rd_en,
    input  logic [1:0]  rd_addr,
    output logic [7:0]  rd_data
);

    alarm_t            alm_evt;
    alarm_t            alm_q;
    logic              clr_alm;
    logic              clr_fas;
    logic              clr_eb;
    logic [FAS_W-1:0]  fas_q;
    logic [EB_W-1:0]   eb_q;

    assign alm_evt = '{rai:   evt_rai,
                       ais:   evt_ais,
                       ais16: evt_ais16,
                       los:   evt_los,
                       aux:   evt_aux,
                       mfa:   evt_mfa,
                       slip:  evt_slip};

    e1_alarm_latch u_alarm (
        .clk (clk),
        .rst (rst),
        .evt (alm_evt),
        .clr (clr_alm),
        .q   (alm_q)
    );

    e1_sat_counter #(.W(FAS_W)) u_fas_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (evt_fas_err),
        .clr   (clr_fas),
        .count (fas_q)
    );

    e1_sat_counter #(.W(EB_W)) u_eb_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (evt_ebit_err),
        .clr   (clr_eb),
        .count (eb_q)
    );

    e1_stat_readout #(.FAS_W(FAS_W), .EB_W(EB_W)) u_readout (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .alm     (alm_q),
        .fas_cnt (fas_q),
        .eb_cnt  (eb_q),
        .clr_alm (clr_alm),
        .clr_fas (clr_fas),
        .clr_eb  (clr_eb),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/e1_alarm_counters_chk.sv
module e1_alarm_counters_chk #(
    parameter int FAS_W = 8,
    parameter int EB_W  = 10
) (
    input logic             clk,
    input logic             rst,
    input logic [6:0]       alm_evt,
    input logic [6:0]       alm_q,
    input logic             rd_en,
    input logic [1:0]       rd_addr,
    input logic [7:0]       rd_data,
    input logic [FAS_W-1:0] fas_q,
    input logic [EB_W-1:0]  eb_q
);

    localparam logic [FAS_W-1:0] FAS_MAX = {FAS_W{1'b1}};
    localparam logic [EB_W-1:0]  EB_MAX  = {EB_W{1'b1}};

    AST_ALARM_READ_VALUE: assert property (@(posedge clk) disable iff (rst)
        $past(rd_en && rd_addr == 2'd0) |-> (rd_data[7:1] == $past(alm_q))); // R1

    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_en && rd_addr == 2'd0) |-> ((alm_q & $past(alm_q)) == $past(alm_q))); // R2

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rd_en && rd_addr == 2'd0) |-> (alm_q == $past(alm_evt))); // R3

    AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (rst)
        ((alm_q & $past(alm_evt)) == $past(alm_evt))); // R4

    AST_FAS_STEP: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_en && rd_addr == 2'd1) |->
            ((fas_q == $past(fas_q)) || (fas_q == FAS_W'($past(fas_q) + 1'b1)))); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        ($past(fas_q) == FAS_MAX && !$past(rd_en && rd_addr == 2'd1)) |->
            (fas_q == FAS_MAX)); // R6

    AST_NO_OVERFLOW_EB: assert property (@(posedge clk) disable iff (rst)
        ($past(eb_q) == EB_MAX && !$past(rd_en && rd_addr == 2'd3)) |->
            (eb_q == EB_MAX)); // R6

    AST_HI_READ_KEEPS: assert property (@(posedge clk) disable iff (rst)
        $past(rd_en && rd_addr == 2'd2) |-> (eb_q >= $past(eb_q))); // R7

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_en) |-> (rd_data == 8'd0)); // R9

endmodule

bind e1_alarm_counters e1_alarm_counters_chk #(.FAS_W(FAS_W), .EB_W(EB_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .alm_evt (alm_evt),
    .alm_q   (alm_q),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .fas_q   (fas_q),
    .eb_q    (eb_q)
);

// File: tb/e1_alarm_counters_test.sv
module e1_alarm_counters_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] ev  = '0;
    logic       fe  = 1'b0;
    logic       ee  = 1'b0;
    logic       re  = 1'b0;
    logic [1:0] ra  = '0;
    logic [7:0] rd_data;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 0;

    int m_alm, m_fas, m_eb, m_snap, m_sv;

    always #(CLK_PERIOD/2) clk = ~clk;

    e1_alarm_counters uut (
        .clk          (clk),
        .rst          (rst),
        .evt_rai      (ev[6]),
        .evt_ais      (ev[5]),
        .evt_ais16    (ev[4]),
        .evt_los      (ev[3]),
        .evt_aux      (ev[2]),
        .evt_mfa      (ev[1]),
        .evt_slip     (ev[0]),
        .evt_fas_err  (fe),
        .evt_ebit_err (ee),
        .rd_en        (re),
        .rd_addr      (ra),
        .rd_data      (rd_data)
    );

    task automatic check(input int exp, input string tag);
        n_cmp++;
        if (rd_data !== exp[7:0]) begin
            n_fail++;
            $display("FAIL %s: rd_data actual %02h expected %02h", tag, rd_data, exp[7:0]);
        end
    endtask

    function automatic string tag_for(input logic r, input logic [1:0] a);
        if (!r) return "R9 idle";
        case (a)
            2'd0: return "R1 R2 R3 R4 alarm byte";
            2'd1: return "R5 R6 fas count";
            2'd2: return "R7 ebit upper";
            default: return "R7 R8 ebit lower";
        endcase
    endfunction

    // One clock: apply inputs, advance the model, compare after the edge.
    task automatic step(input logic [6:0] e, input logic f, input logic b,
                        input logic r, input logic [1:0] a);
        int exp;
        int n_alm, n_fas, n_eb;
        ev = e; fe = f; ee = b; re = r; ra = a;
        exp = 0;
        if (r) begin
            case (a)
                2'd0: exp = m_alm * 2;
                2'd1: exp = m_fas;
                2'd2: exp = m_eb / 256;
                default: exp = m_sv ? m_snap : (m_eb % 256);
            endcase
        end
        n_alm = ((r && a == 2'd0) ? 0 : m_alm) | int'(e);
        if (r && a == 2'd1) n_fas = int'(f);
        else n_fas = (f && m_fas < 255) ? m_fas + 1 : m_fas;
        if (r && a == 2'd3) n_eb = int'(b);
        else n_eb = (b && m_eb < 1023) ? m_eb + 1 : m_eb;
        if (r && a == 2'd2) begin
            m_snap = m_eb % 256;
            m_sv   = 1;
        end else if (r && a == 2'd3) begin
            m_sv = 0;
        end
        m_alm = n_alm; m_fas = n_fas; m_eb = n_eb;
        @(posedge clk);
        @(negedge clk);
        check(exp, tag_for(r, a));
        ev = '0; fe = 0; ee = 0; re = 0;
    endtask

    task automatic apply_reset(input int cycles);
        rst = 1'b1;
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk);
            @(negedge clk);
            check(0, "R10 reset");
        end
        m_alm = 0; m_fas = 0; m_eb = 0; m_snap = 0; m_sv = 0;
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        apply_reset(3);

        // R10: everything reads zero after reset
        for (int a = 0; a < 4; a++) step('0, 0, 0, 1, 2'(a));

        // R1: each alarm bit lands in its own position
        for (int i = 0; i < 7; i++) begin
            step(7'(1 << i), 0, 0, 0, 2'd0);
            step('0, 0, 0, 0, 2'd0);
            step('0, 0, 0, 1, 2'd0);
        end

        // R2 R3: sticky over idle cycles, single read clears
        step(7'h55, 0, 0, 0, 2'd0);
        repeat (5) step('0, 0, 0, 0, 2'd0);
        step('0, 0, 0, 1, 2'd0);
        step('0, 0, 0, 1, 2'd0);

        // R4: event in same cycle as clearing read
        step(7'h08, 0, 0, 0, 2'd0);
        step(7'h40, 0, 0, 1, 2'd0);
        step('0, 0, 0, 1, 2'd0);

        // R5: counting and clear with coincident strobe
        repeat (7) step('0, 1, 0, 0, 2'd0);
        step('0, 1, 0, 1, 2'd1);
        step('0, 0, 0, 1, 2'd1);
        step('0, 0, 0, 1, 2'd1);

        // R6: saturation of both counters
        for (int i = 0; i < 1100; i++) step('0, (i < 300), 1, 0, 2'd0);
        step('0, 0, 0, 1, 2'd1);
        step('0, 0, 0, 1, 2'd2);
        step('0, 0, 0, 1, 2'd3);
        step('0, 0, 0, 1, 2'd3);

        // R7 R8: capture on upper read, then more errors before lower read
        for (int i = 0; i < 300; i++) step('0, 0, 1, 0, 2'd0);
        step('0, 0, 1, 1, 2'd2);
        repeat (20) step('0, 0, 1, 0, 2'd0);
        step('0, 0, 0, 1, 2'd2);
        step('0, 0, 0, 1, 2'd3);
        step('0, 0, 0, 1, 2'd3);
        repeat (4) step('0, 0, 1, 0, 2'd0);
        step('0, 0, 1, 1, 2'd3);
        step('0, 0, 0, 1, 2'd3);

        // Mixed traffic across all inputs
        for (int i = 0; i < 3000; i++) begin
            automatic logic [6:0] e = ($urandom_range(0, 7) == 0) ? 7'($urandom) : 7'd0;
            automatic logic f = ($urandom_range(0, 3) == 0);
            automatic logic b = ($urandom_range(0, 2) == 0);
            automatic logic r = ($urandom_range(0, 5) == 0);
            step(e, f, b, r, 2'($urandom));
        end

        // R10: reset in the middle of activity
        step(7'h7F, 1, 1, 1, 2'd2);
        apply_reset(2);
        for (int a = 0; a < 4; a++) step('0, 0, 0, 1, 2'(a));

        finish_run();
    end

endmodule